// File: doc/BRIEF.md
# NAND Block-Range Write Guard

This block sits between a flash command decoder and the NAND interface logic. Every command arrives on a valid/ready handshake with an opcode and a target block number. The guard decides, in the same cycle, whether the command may go downstream. Reads always go through. Program and erase commands go through only when the target block lies inside a window that software has opened.

Two lock enables control the check. A soft lock can be set and cleared by software at will. A tight lock, once written to 1, stays set until reset or a wake-from-sleep pulse. When either enable is on, the open window is the half-open range from the start register up to, but not including, the end register. Equal bounds therefore leave no open block at all.

A program or erase that is refused is still acknowledged upstream, but it is never presented downstream. The refusal sets a sticky illegal-access flag, which can also drive an interrupt. Software clears the flag with a write-one pulse.

Top module: `nand_range_guard`

## Requirements
- R1: After reset the soft lock reads 1, and the tight lock, interrupt enable, illegal-access flag and interrupt output all read 0.
- R2: A control write (`ctlWe`) loads the soft lock from `softIn`, so the soft lock can be set and cleared repeatedly.
- R3: A control write with `tightIn`=1 sets the tight lock. Later control writes with `tightIn`=0 leave it at 1. Only reset or a `wakeClr` pulse clears it, and `wakeClr` wins over a same-cycle set.
- R4: Opcode encoding is 0 read, 1 program, 2 erase, 3 treated like a read. While either lock is on, a program or erase to block b passes only if start ≤ b < end. A passing command drives `dnValid` in the same cycle with opcode and block unchanged, and `upReady` follows `dnReady`.
- R5: While a lock is on and start equals end, every program and erase is refused.
- R6: Read commands (opcode 0 or 3) pass whatever the locks and window hold.
- R7: A refused command gives `dnValid`=0 and `upReady`=1 in the same cycle, and `illegalFlag` reads 1 from the next cycle.
- R8: With both locks at 0, every command passes and the flag is never set.
- R9: `irq` equals the illegal-access flag ANDed with the interrupt enable, which is loaded by a control write from `irqEnIn`.
- R10: The flag holds until a `flagClr` pulse clears it. A refusal in the same cycle as the clear leaves it set.
- R11: `startWe` and `endWe` load the window bounds whatever the lock state, and the new bounds apply from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| upValid | input | 1 | Command valid from the decoder |
| upReady | output | 1 | Command accepted |
| upOp | input | 2 | Opcode: 0 read, 1 program, 2 erase, 3 read-like |
| upBlk | input | BLK_W | Target block |
| dnValid | output | 1 | Command valid toward the NAND interface |
| dnReady | input | 1 | NAND interface ready |
| dnOp | output | 2 | Forwarded opcode |
| dnBlk | output | BLK_W | Forwarded block |
| ctlWe | input | 1 | Control write strobe |
| softIn | input | 1 | Soft lock value for a control write |
| tightIn | input | 1 | Tight lock set request for a control write |
| irqEnIn | input | 1 | Interrupt enable value for a control write |
| startWe | input | 1 | Start bound write strobe |
| startIn | input | BLK_W | Start bound value |
| endWe | input | 1 | End bound write strobe |
| endIn | input | BLK_W | End bound value |
| flagClr | input | 1 | Write-one clear of the flag |
| wakeClr | input | 1 | Wake-from-sleep pulse, clears the tight lock |
| softLockQ | output | 1 | Soft lock state |
| tightLockQ | output | 1 | Tight lock state |
| startQ | output | BLK_W | Start bound |
| endQ | output | BLK_W | End bound |
| illegalFlag | output | 1 | Sticky illegal-access flag |
| irq | output | 1 | Illegal-access interrupt |

## Verification
The pass or refuse decision on `dnValid` and `upReady` is combinational, so the bench checks it in the cycle the command is presented. The flag, lock, bound and interrupt-enable updates take effect one clock edge after the strobe, and `irq` follows a flag or enable change in that same later cycle. The bench drives inputs on the falling edge and samples one nanosecond later. At each rising edge it advances a reference model, so every registered result is compared in the cycle after its cause, and every handshake result is compared in the cycle of its cause.

// File: rtl/nrg_pkg.sv
package nrg_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_PROG  = 2'd1,
    OP_ERASE = 2'd2,
    OP_RSVD  = 2'd3
  } op_e;

  typedef struct packed {
    logic violation;
    logic flagClr;
    logic ctlWr;
    logic startWr;
    logic endWr;
    logic wake;
  } strobe_t;
endpackage

// File: rtl/nrg_ctrl.sv
module nrg_ctrl
  import nrg_pkg::*;
#(
  parameter int BLK_W = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             upValid,
  output logic             upReady,
  input  logic [1:0]       upOp,
  input  logic [BLK_W-1:0] upBlk,
  output logic             dnValid,
  input  logic             dnReady,
  output logic [1:0]       dnOp,
  output logic [BLK_W-1:0] dnBlk,
  input  logic             softQ,
  input  logic             tightQ,
  input  logic [BLK_W-1:0] startQ,
  input  logic [BLK_W-1:0] endQ,
  input  logic             ctlWe,
  input  logic             startWe,
  input  logic             endWe,
  input  logic             flagClr,
  input  logic             wakeClr,
  output strobe_t          strobe
);
  logic isModify, lockOn, inWindow, allow;

  always_comb begin
    isModify = (upOp == OP_PROG) || (upOp == OP_ERASE);
    lockOn   = softQ | tightQ;
    inWindow = (upBlk >= startQ) && (upBlk < endQ);
    allow    = !lockOn || !isModify || inWindow;
  end

  assign dnValid = upValid & allow;
  assign upReady = allow ? dnReady : 1'b1;
  assign dnOp    = upOp;
  assign dnBlk   = upBlk;

  always_comb begin
    strobe.violation = upValid & ~allow;
    strobe.flagClr   = flagClr;
    strobe.ctlWr     = ctlWe;
    strobe.startWr   = startWe;
    strobe.endWr     = endWe;
    strobe.wake      = wakeClr;
  end

  // R5: equal bounds leave no block open for modification
  p_equal_bounds_r5: assert property (@(posedge clk) disable iff (!rstN)
    (lockOn && startQ == endQ && isModify) |-> !dnValid);

  // R6: reads are never refused
  p_read_pass_r6: assert property (@(posedge clk) disable iff (!rstN)
    (upValid && !isModify) |-> (dnValid && upReady == dnReady));

  // R8: unlocked device forwards everything
  p_unlocked_pass_r8: assert property (@(posedge clk) disable iff (!rstN)
    (upValid && !softQ && !tightQ) |-> (dnValid && !strobe.violation));

  // R7: a refused command is acknowledged and dropped
  p_refuse_ack_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.violation |-> (upReady && !dnValid));
endmodule

// File: rtl/nrg_datapath.sv
module nrg_datapath
  import nrg_pkg::*;
#(
  parameter int BLK_W = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobe,
  input  logic             softIn,
  input  logic             tightIn,
  input  logic             irqEnIn,
  input  logic [BLK_W-1:0] startIn,
  input  logic [BLK_W-1:0] endIn,
  output logic             softQ,
  output logic             tightQ,
  output logic [BLK_W-1:0] startQ,
  output logic [BLK_W-1:0] endQ,
  output logic             flagQ,
  output logic             irq
);
  logic irqEnQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      softQ  <= 1'b1;
      irqEnQ <= 1'b0;
    end else if (strobe.ctlWr) begin
      softQ  <= softIn;
      irqEnQ <= irqEnIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                          tightQ <= 1'b0;
    else if (strobe.wake)               tightQ <= 1'b0;
    else if (strobe.ctlWr && tightIn)   tightQ <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startQ <= '0;
      endQ   <= '0;
    end else begin
      if (strobe.startWr) startQ <= startIn;
      if (strobe.endWr)   endQ   <= endIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 flagQ <= 1'b0;
    else if (strobe.violation) flagQ <= 1'b1;
    else if (strobe.flagClr)   flagQ <= 1'b0;
  end

  assign irq = flagQ & irqEnQ;

  // R3: tight lock survives everything except wake
  p_tight_sticky_r3: assert property (@(posedge clk) disable iff (!rstN)
    (tightQ && !strobe.wake) |=> tightQ);

  p_wake_clears_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wake |=> !tightQ);

  // R7 / R10: a violation always leaves the flag set, even against a clear
  p_flag_set_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.violation |=> flagQ);

  p_flag_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (flagQ && !strobe.flagClr) |=> flagQ);

  // R9: interrupt never fires without the flag
  p_irq_needs_flag_r9: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> flagQ);
endmodule

// File: rtl/nand_range_guard.sv
module nand_range_guard
  import nrg_pkg::*;
#(
  parameter int BLK_W = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             upValid,
  output logic             upReady,
  input  logic [1:0]       upOp,
  input  logic [BLK_W-1:0] upBlk,
  output logic             dnValid,
  input  logic             dnReady,
  output logic [1:0]       dnOp,
  output logic [BLK_W-1:0] dnBlk,
  input  logic             ctlWe,
  input  logic             softIn,
  input  logic             tightIn,
  input  logic             irqEnIn,
  input  logic             startWe,
  input  logic [BLK_W-1:0] startIn,
  input  logic             endWe,
  input  logic [BLK_W-1:0] endIn,
  input  logic             flagClr,
  input  logic             wakeClr,
  output logic             softLockQ,
  output logic             tightLockQ,
  output logic [BLK_W-1:0] startQ,
  output logic [BLK_W-1:0] endQ,
  output logic             illegalFlag,
  output logic             irq
);
  strobe_t strobe;

  nrg_ctrl #(.BLK_W(BLK_W)) uCtrl (
    .clk(clk), .rstN(rstN),
    .upValid(upValid), .upReady(upReady), .upOp(upOp), .upBlk(upBlk),
    .dnValid(dnValid), .dnReady(dnReady), .dnOp(dnOp), .dnBlk(dnBlk),
    .softQ(softLockQ), .tightQ(tightLockQ), .startQ(startQ), .endQ(endQ),
    .ctlWe(ctlWe), .startWe(startWe), .endWe(endWe),
    .flagClr(flagClr), .wakeClr(wakeClr), .strobe(strobe)
  );

  nrg_datapath #(.BLK_W(BLK_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .softIn(softIn), .tightIn(tightIn), .irqEnIn(irqEnIn),
    .startIn(startIn), .endIn(endIn),
    .softQ(softLockQ), .tightQ(tightLockQ), .startQ(startQ), .endQ(endQ),
    .flagQ(illegalFlag), .irq(irq)
  );
endmodule

// File: tb/nand_range_guard_test.sv
module nand_range_guard_test;
  localparam int BW = 11;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic upValid = 0, dnReady = 0, ctlWe = 0, softIn = 0, tightIn = 0, irqEnIn = 0;
  logic startWe = 0, endWe = 0, flagClr = 0, wakeClr = 0;
  logic [1:0] upOp = 0;
  logic [BW-1:0] upBlk = 0, startIn = 0, endIn = 0;
  logic upReady, dnValid, softLockQ, tightLockQ, illegalFlag, irq;
  logic [1:0] dnOp;
  logic [BW-1:0] dnBlk, startQ, endQ;

  nand_range_guard #(.BLK_W(BW)) uut (.*);

  always #4 clk = ~clk;

  int nChecks = 0, nFails = 0;
  logic mSoft = 1, mTight = 0, mIrqEn = 0, mFlag = 0;
  logic [BW-1:0] mStart = 0, mEnd = 0;

  function automatic logic expAllow(logic [1:0] op, logic [BW-1:0] b);
    logic modify = (op == 2'd1) || (op == 2'd2);
    if (!(mSoft || mTight) || !modify) return 1'b1;
    return (b >= mStart) && (b < mEnd);
  endfunction

  task automatic chk(string req, string what, longint act, longint exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic checkAll(string tag);
    logic al = expAllow(upOp, upBlk);
    chk({"R4 ", tag}, "dnValid", dnValid, upValid & al);
    chk({"R7 ", tag}, "upReady", upReady, al ? dnReady : 1'b1);
    if (dnValid) begin
      chk({"R4 ", tag}, "dnOp", dnOp, upOp);
      chk({"R4 ", tag}, "dnBlk", dnBlk, upBlk);
    end
    chk({"R10 ", tag}, "flag", illegalFlag, mFlag);
    chk({"R9 ", tag}, "irq", irq, mFlag & mIrqEn);
    chk({"R2 ", tag}, "soft", softLockQ, mSoft);
    chk({"R3 ", tag}, "tight", tightLockQ, mTight);
    chk({"R11 ", tag}, "start", startQ, mStart);
    chk({"R11 ", tag}, "end", endQ, mEnd);
  endtask

  // one cycle: inputs already driven after a falling edge
  task automatic cycle(string tag);
    logic viol;
    #1;
    checkAll(tag);
    viol = upValid & ~expAllow(upOp, upBlk);
    @(posedge clk);
    if (viol) mFlag = 1;
    else if (flagClr) mFlag = 0;
    if (ctlWe) begin mSoft = softIn; mIrqEn = irqEnIn; end
    if (wakeClr) mTight = 0;
    else if (ctlWe && tightIn) mTight = 1;
    if (startWe) mStart = startIn;
    if (endWe) mEnd = endIn;
    @(negedge clk);
    upValid = 0; ctlWe = 0; startWe = 0; endWe = 0; flagClr = 0; wakeClr = 0;
  endtask

  task automatic cmd(logic [1:0] op, logic [BW-1:0] b, string tag);
    upValid = 1; upOp = op; upBlk = b; dnReady = 1;
    cycle(tag);
  endtask

  task automatic ctl(logic s, logic t, logic ie);
    ctlWe = 1; softIn = s; tightIn = t; irqEnIn = ie;
    cycle("ctl");
  endtask

  task automatic win(logic [BW-1:0] s, logic [BW-1:0] e);
    startWe = 1; startIn = s; endWe = 1; endIn = e;
    cycle("R11 window");
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    process::self().srandom(32'h5eed_1234);
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    cycle("R1 reset");
    // R4 window 4..8 with soft lock
    win(4, 8);
    cmd(2'd1, 3, "R4 below");
    cmd(2'd1, 4, "R4 start edge");
    cmd(2'd2, 7, "R4 last open");
    cmd(2'd2, 8, "R4 end edge");
    // R6 reads pass in locked area
    cmd(2'd0, 100, "R6 read");
    cmd(2'd3, 2, "R6 rsvd");
    // R10 clear with simultaneous violation keeps flag
    flagClr = 1; cmd(2'd1, 9, "R10 clr+viol");
    flagClr = 1; cycle("R10 clear");
    // R9 interrupt
    ctl(1, 0, 1);
    cmd(2'd2, 0, "R9 irq set");
    cycle("R9 irq");
    flagClr = 1; cycle("R9 irq clr");
    // R5 equal bounds
    win(5, 5);
    cmd(2'd1, 5, "R5 equal");
    cmd(2'd0, 5, "R5 read");
    // R8 locks off
    ctl(0, 0, 0);
    flagClr = 1; cycle("R8 clr");
    cmd(2'd1, 5, "R8 prog");
    cmd(2'd2, 1000, "R8 erase");
    // R3 tight lock sticky, wake clears
    ctl(0, 1, 0);
    ctl(0, 0, 0);
    cmd(2'd1, 5, "R3 tight");
    win(2, 6);
    cmd(2'd1, 5, "R3 R11 new window");
    wakeClr = 1; ctlWe = 1; tightIn = 1; softIn = 0; cycle("R3 wake wins");
    cmd(2'd1, 0, "R3 after wake");
    // backpressure while allowed
    upValid = 1; upOp = 2'd1; upBlk = 0; dnReady = 0; cycle("R4 stall");
    // random mix
    for (int i = 0; i < 3000; i++) begin
      upValid = ($urandom % 4) != 0;
      upOp    = 2'($urandom);
      upBlk   = BW'($urandom % 16);
      dnReady = $urandom % 2;
      ctlWe   = ($urandom % 8) == 0;
      softIn  = $urandom % 2;
      tightIn = ($urandom % 4) == 0;
      irqEnIn = $urandom % 2;
      startWe = ($urandom % 10) == 0;
      startIn = BW'($urandom % 16);
      endWe   = ($urandom % 10) == 0;
      endIn   = BW'($urandom % 16);
      flagClr = ($urandom % 6) == 0;
      wakeClr = ($urandom % 20) == 0;
      cycle("random");
    end
    summary();
  end
endmodule